// File: doc/BRIEF.md
# Tagged Fully Associative Translation Buffer

This block keeps a small set of recently used page table entries close to the processor. A lookup is checked against every stored entry in parallel. A hit returns the physical address one clock later, with no access to memory. That address is the stored frame number followed by the untouched in-page offset. A lookup that finds nothing raises a miss fault, so that software or an external table walker can fetch the entry and write it back through the refill port. A store that lands on a read-only entry raises a protection fault instead of a hit.

Every entry carries a process-id tag. A hit needs that tag to equal the current process-id register, so mappings from several processes can live side by side. For context switches the block offers two further choices. A full flush wipes every entry and sends the replacement pointer back to slot 0. A valid clear drops only the valid bits and leaves the pointer where it was.

A refill either names its slot or lets the block choose one. When the block chooses, it takes the first free slot found going round from a rotating pointer, and the current pointer slot if none is free. A refill whose page and tag already match a live entry always rewrites that entry, so the buffer never holds two copies of one mapping.

Top module: `tagged_tlb`

## Requirements
- R1: After reset every entry is invalid, rsp_valid_o is low and the replacement pointer is at slot 0, so the first hardware-chosen refill reports slot 0.
- R2: A lookup presented in cycle t produces registered outputs in cycle t+1. There rsp_valid_o is high and exactly one of rsp_hit_o, rsp_miss_o and rsp_prot_o is high. With no lookup, all response outputs are zero.
- R3: A hit needs an entry whose V flag is set, whose page equals lk_page_i and whose tag equals the current process-id register. rsp_paddr_o is then {frame, lk_off_i}, and rsp_flags_o gives the stored flags with V at bit 0, W at bit 1, R at bit 2 and D at bit 3.
- R4: With no matching entry, rsp_miss_o is raised and rsp_paddr_o and rsp_flags_o are zero.
- R5: An entry tagged with another process id never hits. A write to the current process-id register affects lookups from the next cycle on.
- R6: A store lookup (lk_store_i high) that matches an entry with W clear raises rsp_prot_o, with address and flags zero. A load to the same entry hits.
- R7: ctx_op_i = 2'b01 (flush) clears every entry and returns the replacement pointer to slot 0.
- R8: ctx_op_i = 2'b10 (valid clear) clears the V flag of every entry and leaves the replacement pointer unchanged.
- R9: A refill with fill_use_slot_i high writes the slot given by fill_slot_i and leaves the pointer unchanged.
- R10: A refill with fill_use_slot_i low uses the first slot without V found going round from the pointer, or the pointer slot if all are valid. The pointer then moves to the slot after the one written. fill_slot_o shows the slot chosen for any refill.
- R11: A refill whose page and tag equal those of a valid entry rewrites that entry, whatever slot was requested, and does not move the pointer.
- R12: A flush or valid clear in the same cycle as a refill discards the refill. A lookup in the same cycle as a refill, context operation or process-id write sees the state from before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pid_we_i | input | 1 | Write the current process-id register |
| pid_i | input | PID_W | New current process id |
| lk_valid_i | input | 1 | Lookup request |
| lk_store_i | input | 1 | Lookup is for a store |
| lk_page_i | input | PAGE_W | Page number to translate |
| lk_off_i | input | OFF_W | Offset within the page |
| rsp_valid_o | output | 1 | Lookup result present |
| rsp_hit_o | output | 1 | Translation succeeded |
| rsp_miss_o | output | 1 | Miss fault |
| rsp_prot_o | output | 1 | Protection fault on store |
| rsp_paddr_o | output | FRAME_W+OFF_W | Physical address on hit |
| rsp_flags_o | output | 4 | Stored flags on hit (D,R,W,V from bit 3 down to bit 0) |
| fill_i | input | 1 | Refill request |
| fill_use_slot_i | input | 1 | Use fill_slot_i rather than the hardware choice |
| fill_slot_i | input | IDX_W | Requested slot |
| fill_page_i | input | PAGE_W | Page number of new entry |
| fill_pid_i | input | PID_W | Process-id tag of new entry |
| fill_frame_i | input | FRAME_W | Frame number of new entry |
| fill_flags_i | input | 4 | Flags of new entry |
| fill_slot_o | output | IDX_W | Slot chosen for the current refill |
| ctx_op_i | input | 2 | 00 none, 01 flush, 10 valid clear, 11 none |

## Verification
The bench builds the block with ENTRIES=4 and PID_W=3, and keeps the default page, offset and frame widths. With four slots, a handful of refills fills the buffer and wraps the pointer, and every slot's choice can be predicted. Directed sequences cover the dedup, valid-clear and flush cases. A small page range and three-bit tags make hits, cross-process misses and rewrites of live entries frequent in the random phase that follows.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  // flag bit positions inside a stored entry
  localparam int FLG_V = 0;
  localparam int FLG_W = 1;

  typedef logic [3:0] flags_t;

  typedef enum logic [1:0] {
    CTX_NONE  = 2'b00,
    CTX_FLUSH = 2'b01,
    CTX_VCLR  = 2'b10,
    CTX_RSVD  = 2'b11
  } ctx_op_e;

endpackage

// File: rtl/tlb_rst_sync.sv
module tlb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_no
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];

endmodule

// File: rtl/tlb_entry_store.sv
module tlb_entry_store import tlb_pkg::*; #(
  parameter int ENTRIES = 16,
  parameter int PAGE_W  = 11,
  parameter int FRAME_W = 19,
  parameter int PID_W   = 6,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              flush_i,
  input  logic                              vclr_i,
  input  logic                              wr_en_i,
  input  logic [IDX_W-1:0]                  wr_idx_i,
  input  logic [PAGE_W-1:0]                 wr_page_i,
  input  logic [PID_W-1:0]                  wr_pid_i,
  input  logic [FRAME_W-1:0]                wr_frame_i,
  input  flags_t                            wr_flags_i,
  output logic [ENTRIES-1:0][PAGE_W-1:0]    page_o,
  output logic [ENTRIES-1:0][PID_W-1:0]     pid_o,
  output logic [ENTRIES-1:0][FRAME_W-1:0]   frame_o,
  output logic [ENTRIES-1:0][3:0]           flags_o,
  output logic [ENTRIES-1:0]                valid_o
);

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic [PAGE_W-1:0]  page_q,  page_d;
    logic [PID_W-1:0]   pid_q,   pid_d;
    logic [FRAME_W-1:0] frame_q, frame_d;
    flags_t             flg_q,   flg_d;
    logic               ent_en;

    always_comb begin
      page_d  = page_q;
      pid_d   = pid_q;
      frame_d = frame_q;
      flg_d   = flg_q;
      ent_en  = flush_i | vclr_i | (wr_en_i && (wr_idx_i == IDX_W'(e)));
      if (flush_i) begin
        page_d  = '0;
        pid_d   = '0;
        frame_d = '0;
        flg_d   = '0;
      end else if (vclr_i) begin
        flg_d[FLG_V] = 1'b0;
      end else if (wr_en_i) begin
        page_d  = wr_page_i;
        pid_d   = wr_pid_i;
        frame_d = wr_frame_i;
        flg_d   = wr_flags_i;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        page_q  <= '0;
        pid_q   <= '0;
        frame_q <= '0;
        flg_q   <= '0;
      end else if (ent_en) begin
        page_q  <= page_d;
        pid_q   <= pid_d;
        frame_q <= frame_d;
        flg_q   <= flg_d;
      end
    end

    assign page_o[e]  = page_q;
    assign pid_o[e]   = pid_q;
    assign frame_o[e] = frame_q;
    assign flags_o[e] = flg_q;
    assign valid_o[e] = flg_q[FLG_V];
  end

  // R7: a flush leaves no live entry behind
  a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (valid_o == '0));

  // R8: a valid clear drops the live bits but keeps the keys
  a_r8_vclr_keeps_keys: assert property (@(posedge clk) disable iff (!rst_n)
    (vclr_i && !flush_i) |=> ((valid_o == '0) && $stable(page_o) && $stable(frame_o)));

endmodule

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int ENTRIES = 16,
  parameter int PAGE_W  = 11,
  parameter int PID_W   = 6,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0]             valid_i,
  input  logic [ENTRIES-1:0][PAGE_W-1:0] page_i,
  input  logic [ENTRIES-1:0][PID_W-1:0]  pid_i,
  input  logic [PAGE_W-1:0]              key_page_i,
  input  logic [PID_W-1:0]               key_pid_i,
  output logic [ENTRIES-1:0]             hit_vec_o,
  output logic                           any_o,
  output logic [IDX_W-1:0]               idx_o
);

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign hit_vec_o[e] = valid_i[e] && (page_i[e] == key_page_i) && (pid_i[e] == key_pid_i);
  end

  assign any_o = |hit_vec_o;

  always_comb begin
    idx_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec_o[i]) idx_o = IDX_W'(i);
    end
  end

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid_i,
  input  logic               adv_i,
  input  logic [IDX_W-1:0]   adv_from_i,
  input  logic               home_i,
  output logic [IDX_W-1:0]   victim_o,
  output logic [IDX_W-1:0]   ptr_o
);

  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic             ptr_en;
  logic             found;

  // first free slot going round from the pointer, else the pointer
  always_comb begin
    found    = 1'b0;
    victim_o = ptr_q;
    for (int k = 0; k < ENTRIES; k++) begin
      int c;
      c = int'(ptr_q) + k;
      if (c >= ENTRIES) c = c - ENTRIES;
      if (!found && !valid_i[c]) begin
        victim_o = IDX_W'(c);
        found    = 1'b1;
      end
    end
  end

  always_comb begin
    ptr_d  = ptr_q;
    ptr_en = home_i | adv_i;
    if (home_i)     ptr_d = '0;
    else if (adv_i) ptr_d = (int'(adv_from_i) == ENTRIES - 1) ? '0 : adv_from_i + IDX_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;

  // R10: the pointer stays inside the table
  a_r10_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr_q) < ENTRIES);

  // R10: while a free slot exists the choice is a free slot
  a_r10_victim_free: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i != {ENTRIES{1'b1}}) |-> !valid_i[victim_o]);

  // R7: flush sends the pointer home
  a_r7_ptr_home: assert property (@(posedge clk) disable iff (!rst_n)
    home_i |=> (ptr_q == '0));

endmodule

// File: rtl/tagged_tlb.sv
module tagged_tlb import tlb_pkg::*; #(
  parameter int ENTRIES = 16,
  parameter int PAGE_W  = 11,
  parameter int OFF_W   = 13,
  parameter int FRAME_W = 19,
  parameter int PID_W   = 6,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int PA_W   = FRAME_W + OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pid_we_i,
  input  logic [PID_W-1:0]   pid_i,
  input  logic               lk_valid_i,
  input  logic               lk_store_i,
  input  logic [PAGE_W-1:0]  lk_page_i,
  input  logic [OFF_W-1:0]   lk_off_i,
  output logic               rsp_valid_o,
  output logic               rsp_hit_o,
  output logic               rsp_miss_o,
  output logic               rsp_prot_o,
  output logic [PA_W-1:0]    rsp_paddr_o,
  output logic [3:0]         rsp_flags_o,
  input  logic               fill_i,
  input  logic               fill_use_slot_i,
  input  logic [IDX_W-1:0]   fill_slot_i,
  input  logic [PAGE_W-1:0]  fill_page_i,
  input  logic [PID_W-1:0]   fill_pid_i,
  input  logic [FRAME_W-1:0] fill_frame_i,
  input  logic [3:0]         fill_flags_i,
  output logic [IDX_W-1:0]   fill_slot_o,
  input  logic [1:0]         ctx_op_i
);

  logic rst_ni;

  tlb_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_no (rst_ni)
  );

  // current process id
  logic [PID_W-1:0] cur_pid_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)       cur_pid_q <= '0;
    else if (pid_we_i) cur_pid_q <= pid_i;
  end

  // context operation decode
  ctx_op_e ctx_op;
  logic    do_flush, do_vclr;

  assign ctx_op   = ctx_op_e'(ctx_op_i);
  assign do_flush = (ctx_op == CTX_FLUSH);
  assign do_vclr  = (ctx_op == CTX_VCLR);

  // entry storage
  logic [ENTRIES-1:0][PAGE_W-1:0]  ent_page;
  logic [ENTRIES-1:0][PID_W-1:0]   ent_pid;
  logic [ENTRIES-1:0][FRAME_W-1:0] ent_frame;
  logic [ENTRIES-1:0][3:0]         ent_flags;
  logic [ENTRIES-1:0]              ent_valid;
  logic                            fill_go;
  logic [IDX_W-1:0]                slot_sel;

  tlb_entry_store #(
    .ENTRIES (ENTRIES),
    .PAGE_W  (PAGE_W),
    .FRAME_W (FRAME_W),
    .PID_W   (PID_W)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_ni),
    .flush_i    (do_flush),
    .vclr_i     (do_vclr),
    .wr_en_i    (fill_go),
    .wr_idx_i   (slot_sel),
    .wr_page_i  (fill_page_i),
    .wr_pid_i   (fill_pid_i),
    .wr_frame_i (fill_frame_i),
    .wr_flags_i (flags_t'(fill_flags_i)),
    .page_o     (ent_page),
    .pid_o      (ent_pid),
    .frame_o    (ent_frame),
    .flags_o    (ent_flags),
    .valid_o    (ent_valid)
  );

  // lookup match against the current process
  logic [ENTRIES-1:0] lk_vec;
  logic               lk_any;
  logic [IDX_W-1:0]   lk_idx;

  tlb_match #(
    .ENTRIES (ENTRIES),
    .PAGE_W  (PAGE_W),
    .PID_W   (PID_W)
  ) u_lk_match (
    .valid_i    (ent_valid),
    .page_i     (ent_page),
    .pid_i      (ent_pid),
    .key_page_i (lk_page_i),
    .key_pid_i  (cur_pid_q),
    .hit_vec_o  (lk_vec),
    .any_o      (lk_any),
    .idx_o      (lk_idx)
  );

  // refill duplicate detection against the refill's own tag
  logic [ENTRIES-1:0] dup_vec;
  logic               dup_any;
  logic [IDX_W-1:0]   dup_idx;

  tlb_match #(
    .ENTRIES (ENTRIES),
    .PAGE_W  (PAGE_W),
    .PID_W   (PID_W)
  ) u_dup_match (
    .valid_i    (ent_valid),
    .page_i     (ent_page),
    .pid_i      (ent_pid),
    .key_page_i (fill_page_i),
    .key_pid_i  (fill_pid_i),
    .hit_vec_o  (dup_vec),
    .any_o      (dup_any),
    .idx_o      (dup_idx)
  );

  // replacement choice
  logic [IDX_W-1:0] victim;
  logic [IDX_W-1:0] rr_ptr;
  logic             rr_adv;

  tlb_victim #(
    .ENTRIES (ENTRIES)
  ) u_victim (
    .clk        (clk),
    .rst_n      (rst_ni),
    .valid_i    (ent_valid),
    .adv_i      (rr_adv),
    .adv_from_i (slot_sel),
    .home_i     (do_flush),
    .victim_o   (victim),
    .ptr_o      (rr_ptr)
  );

  always_comb begin
    if (dup_any)              slot_sel = dup_idx;
    else if (fill_use_slot_i) slot_sel = fill_slot_i;
    else                      slot_sel = victim;
  end

  assign fill_go     = fill_i && !do_flush && !do_vclr;
  assign rr_adv      = fill_go && !dup_any && !fill_use_slot_i;
  assign fill_slot_o = slot_sel;

  // response next state
  logic [FRAME_W-1:0] sel_frame;
  flags_t             sel_flags;
  logic               rsp_valid_d, rsp_hit_d, rsp_miss_d, rsp_prot_d;
  logic [PA_W-1:0]    rsp_paddr_d;
  logic [3:0]         rsp_flags_d;
  logic               rsp_en;

  assign sel_frame = ent_frame[lk_idx];
  assign sel_flags = flags_t'(ent_flags[lk_idx]);

  always_comb begin
    rsp_valid_d = 1'b0;
    rsp_hit_d   = 1'b0;
    rsp_miss_d  = 1'b0;
    rsp_prot_d  = 1'b0;
    rsp_paddr_d = '0;
    rsp_flags_d = '0;
    if (lk_valid_i) begin
      rsp_valid_d = 1'b1;
      if (!lk_any) begin
        rsp_miss_d = 1'b1;
      end else if (lk_store_i && !sel_flags[FLG_W]) begin
        rsp_prot_d = 1'b1;
      end else begin
        rsp_hit_d   = 1'b1;
        rsp_paddr_d = {sel_frame, lk_off_i};
        rsp_flags_d = sel_flags;
      end
    end
  end

  assign rsp_en = lk_valid_i | rsp_valid_o;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_miss_o  <= 1'b0;
      rsp_prot_o  <= 1'b0;
      rsp_paddr_o <= '0;
      rsp_flags_o <= '0;
    end else if (rsp_en) begin
      rsp_valid_o <= rsp_valid_d;
      rsp_hit_o   <= rsp_hit_d;
      rsp_miss_o  <= rsp_miss_d;
      rsp_prot_o  <= rsp_prot_d;
      rsp_paddr_o <= rsp_paddr_d;
      rsp_flags_o <= rsp_flags_d;
    end
  end

  // R2: one outcome per accepted lookup, and only then
  a_r2_one_outcome: assert property (@(posedge clk) disable iff (!rst_ni)
    rsp_valid_o == ($countones({rsp_hit_o, rsp_miss_o, rsp_prot_o}) == 1));

  // R2: a lookup is answered on the next cycle
  a_r2_answer_next: assert property (@(posedge clk) disable iff (!rst_ni)
    lk_valid_i |=> rsp_valid_o);

  // R4: a miss carries no address or flags
  a_r4_miss_clean: assert property (@(posedge clk) disable iff (!rst_ni)
    rsp_miss_o |-> ((rsp_paddr_o == '0) && (rsp_flags_o == '0)));

  // R6: a protection fault only follows a store lookup
  a_r6_prot_on_store: assert property (@(posedge clk) disable iff (!rst_ni)
    rsp_prot_o |-> $past(lk_store_i));

  // R11: the table never holds two live copies of one mapping
  a_r11_single_lk_match: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0(lk_vec));
  a_r11_single_dup_match: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0(dup_vec));

  // R1: the pointer is at slot 0 on leaving reset
  a_r1_ptr_reset: assert property (@(posedge clk)
    $rose(rst_ni) |-> (rr_ptr == '0));

endmodule

// File: tb/tb_tagged_tlb.sv
module tb_tagged_tlb;

  localparam int N = 4;

  logic clk;
  logic rst_n;

  logic        pid_we;
  logic [2:0]  pid_in;
  logic        lk, st;
  logic [10:0] lpg;
  logic [12:0] loff;
  logic        fill, use_slot;
  logic [1:0]  fslot;
  logic [10:0] fpg;
  logic [2:0]  fpid;
  logic [18:0] ffr;
  logic [3:0]  ffl;
  logic [1:0]  ctx;

  logic        rsp_valid_o, rsp_hit_o, rsp_miss_o, rsp_prot_o;
  logic [31:0] rsp_paddr_o;
  logic [3:0]  rsp_flags_o;
  logic [1:0]  fill_slot_o;

  tagged_tlb #(.ENTRIES(N), .PID_W(3)) dut (
    .clk             (clk),
    .rst_n           (rst_n),
    .pid_we_i        (pid_we),
    .pid_i           (pid_in),
    .lk_valid_i      (lk),
    .lk_store_i      (st),
    .lk_page_i       (lpg),
    .lk_off_i        (loff),
    .rsp_valid_o     (rsp_valid_o),
    .rsp_hit_o       (rsp_hit_o),
    .rsp_miss_o      (rsp_miss_o),
    .rsp_prot_o      (rsp_prot_o),
    .rsp_paddr_o     (rsp_paddr_o),
    .rsp_flags_o     (rsp_flags_o),
    .fill_i          (fill),
    .fill_use_slot_i (use_slot),
    .fill_slot_i     (fslot),
    .fill_page_i     (fpg),
    .fill_pid_i      (fpid),
    .fill_frame_i    (ffr),
    .fill_flags_i    (ffl),
    .fill_slot_o     (fill_slot_o),
    .ctx_op_i        (ctx)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int    total = 0;
  int    bad   = 0;
  bit    done  = 0;
  string scen  = "R1";

  // behavioural reference state
  logic [10:0] m_page [N];
  logic [2:0]  m_pid  [N];
  logic [18:0] m_frame[N];
  logic [3:0]  m_flg  [N];
  int          m_ptr;
  logic [2:0]  m_cur;

  logic        e_valid, e_hit, e_miss, e_prot;
  logic [31:0] e_pa;
  logic [3:0]  e_fl;

  task automatic chk(string rq, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic idle_in();
    pid_we = 0; pid_in = 0; lk = 0; st = 0; lpg = 0; loff = 0;
    fill = 0; use_slot = 0; fslot = 0; fpg = 0; fpid = 0; ffr = 0; ffl = 0;
    ctx = 0;
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin
      m_page[i] = 0; m_pid[i] = 0; m_frame[i] = 0; m_flg[i] = 0;
    end
    m_ptr = 0;
    m_cur = 0;
  endtask

  task automatic model_step();
    int found;
    int dup;
    int slot;
    e_valid = lk; e_hit = 0; e_miss = 0; e_prot = 0; e_pa = 0; e_fl = 0;
    if (lk) begin
      found = -1;
      for (int i = 0; i < N; i++)
        if (m_flg[i][0] && m_page[i] == lpg && m_pid[i] == m_cur) found = i;
      if (found < 0) e_miss = 1;
      else if (st && !m_flg[found][1]) e_prot = 1;
      else begin
        e_hit = 1;
        e_pa  = {m_frame[found], loff};
        e_fl  = m_flg[found];
      end
    end
    if (fill) begin
      dup = -1;
      for (int i = 0; i < N; i++)
        if (m_flg[i][0] && m_page[i] == fpg && m_pid[i] == fpid) dup = i;
      if (dup >= 0) slot = dup;
      else if (use_slot) slot = fslot;
      else begin
        slot = m_ptr;
        for (int k = N - 1; k >= 0; k--)
          if (!m_flg[(m_ptr + k) % N][0]) slot = (m_ptr + k) % N;
      end
      chk(scen, "fill_slot", fill_slot_o, slot);
      if (ctx != 2'b01 && ctx != 2'b10) begin
        m_page[slot] = fpg; m_pid[slot] = fpid; m_frame[slot] = ffr; m_flg[slot] = ffl;
        if (dup < 0 && !use_slot) m_ptr = (slot + 1) % N;
      end
    end
    if (ctx == 2'b01) begin
      for (int i = 0; i < N; i++) begin
        m_page[i] = 0; m_pid[i] = 0; m_frame[i] = 0; m_flg[i] = 0;
      end
      m_ptr = 0;
    end else if (ctx == 2'b10) begin
      for (int i = 0; i < N; i++) m_flg[i][0] = 1'b0;
    end
    if (pid_we) m_cur = pid_in;
  endtask

  // one clock: inputs already driven at the falling edge
  task automatic tick();
    #1;
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk(scen, "rsp_valid", rsp_valid_o, e_valid);
    chk(scen, "rsp_hit",   rsp_hit_o,   e_hit);
    chk(scen, "rsp_miss",  rsp_miss_o,  e_miss);
    chk(scen, "rsp_prot",  rsp_prot_o,  e_prot);
    chk(scen, "rsp_paddr", rsp_paddr_o, e_pa);
    chk(scen, "rsp_flags", rsp_flags_o, e_fl);
    idle_in();
  endtask

  task automatic set_look(input logic [10:0] pg, input logic [12:0] off, input logic store);
    lk = 1; lpg = pg; loff = off; st = store;
  endtask

  task automatic set_fill(input logic [10:0] pg, input logic [2:0] pid,
                          input logic [18:0] fr, input logic [3:0] fl);
    fill = 1; fpg = pg; fpid = pid; ffr = fr; ffl = fl;
  endtask

  task automatic look(input logic [10:0] pg, input logic [12:0] off, input logic store);
    set_look(pg, off, store);
    tick();
  endtask

  task automatic fill_auto(input logic [10:0] pg, input logic [2:0] pid,
                           input logic [18:0] fr, input logic [3:0] fl);
    set_fill(pg, pid, fr, fl);
    tick();
  endtask

  task automatic fill_at(input logic [1:0] s, input logic [10:0] pg, input logic [2:0] pid,
                         input logic [18:0] fr, input logic [3:0] fl);
    set_fill(pg, pid, fr, fl);
    use_slot = 1; fslot = s;
    tick();
  endtask

  // flags: V=1 W=2 R=4 D=8
  initial begin
    idle_in();
    model_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1: quiet outputs after reset, empty table, pointer at 0
    scen = "R1";
    chk("R1", "rsp_valid after reset", rsp_valid_o, 0);
    chk("R1", "rsp_paddr after reset", rsp_paddr_o, 0);
    look(11'd5, 13'd0, 0);
    fill_auto(11'd5, 3'd0, 19'h12345, 4'h3);

    // R3: hit returns frame and offset and flags; store allowed with W
    scen = "R3";
    look(11'd5, 13'h1ABC, 0);
    look(11'd5, 13'h0007, 1);
    chk("R3", "hit address", rsp_paddr_o, {19'h12345, 13'h0007});

    // R4: unknown page misses cleanly
    scen = "R4";
    look(11'd6, 13'h1FFF, 0);
    chk("R4", "miss raised", rsp_miss_o, 1);

    // R6: read-only entry faults on store, hits on load
    scen = "R6";
    fill_auto(11'd7, 3'd0, 19'h00777, 4'h5);
    look(11'd7, 13'h0010, 1);
    chk("R6", "prot raised", rsp_prot_o, 1);
    look(11'd7, 13'h0010, 0);

    // R5 / R12: pid write with a lookup in the same cycle uses the old pid
    scen = "R12";
    set_look(11'd5, 13'h0001, 0);
    pid_we = 1; pid_in = 3'd3;
    tick();
    scen = "R5";
    look(11'd5, 13'h0001, 0);
    chk("R5", "other pid misses", rsp_miss_o, 1);
    fill_auto(11'd5, 3'd3, 19'h55555, 4'hB);
    look(11'd5, 13'h0002, 1);
    pid_we = 1; pid_in = 3'd0;
    tick();
    look(11'd5, 13'h0003, 0);

    // R10: fill to full, then wrap the pointer
    scen = "R10";
    fill_auto(11'd9,  3'd0, 19'h00009, 4'h3);
    fill_auto(11'd10, 3'd0, 19'h0000A, 4'h3);
    fill_auto(11'd11, 3'd0, 19'h0000B, 4'h3);
    look(11'd5, 13'h0000, 0);
    look(11'd10, 13'h0004, 0);

    // R11: refill of a live mapping rewrites it despite the slot request
    scen = "R11";
    fill_at(2'd0, 11'd9, 3'd0, 19'h00099, 4'h7);
    look(11'd9, 13'h0005, 0);
    chk("R11", "rewritten frame", rsp_paddr_o, {19'h00099, 13'h0005});

    // R9: explicit slot
    scen = "R9";
    fill_at(2'd2, 11'd12, 3'd0, 19'h00C0C, 4'h3);
    look(11'd12, 13'h0006, 0);

    // R8: valid clear keeps the pointer
    scen = "R8";
    ctx = 2'b10;
    tick();
    look(11'd12, 13'h0006, 0);
    chk("R8", "cleared entry misses", rsp_miss_o, 1);
    fill_auto(11'd13, 3'd0, 19'h0000D, 4'h3);

    // R12: refill and lookup in one cycle; refill killed by flush
    scen = "R12";
    set_fill(11'd14, 3'd0, 19'h0000E, 4'h3);
    set_look(11'd14, 13'h0000, 0);
    tick();
    look(11'd14, 13'h0000, 0);
    set_fill(11'd15, 3'd0, 19'h0000F, 4'h3);
    ctx = 2'b01;
    tick();
    look(11'd15, 13'h0000, 0);
    chk("R12", "dropped refill misses", rsp_miss_o, 1);

    // R7: flush returns the pointer to slot 0
    scen = "R7";
    fill_auto(11'd20, 3'd0, 19'h00020, 4'h3);
    fill_auto(11'd21, 3'd0, 19'h00021, 4'h3);
    ctx = 2'b01;
    tick();
    look(11'd20, 13'h0000, 0);
    fill_auto(11'd22, 3'd0, 19'h00022, 4'h3);
    chk("R7", "slot after flush", m_ptr, 1);

    // R2: mixed traffic compared every cycle
    scen = "R2";
    for (int n = 0; n < 600; n++) begin
      int r;
      r = $urandom_range(0, 65535);
      lk  = r[0]; st = r[1]; lpg = 11'(r[4:2]); loff = 13'($urandom_range(0, 8191));
      fill = r[5] & r[6]; use_slot = r[7]; fslot = 2'(r[9:8]);
      fpg = 11'($urandom_range(0, 7)); fpid = 3'($urandom_range(0, 1));
      ffr = 19'($urandom_range(0, 524287)); ffl = 4'($urandom_range(0, 15));
      pid_we = (r[12:10] == 3'd0); pid_in = 3'($urandom_range(0, 1));
      ctx = (r[15:13] == 3'd0) ? 2'($urandom_range(0, 3)) : 2'b00;
      tick();
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R2 watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule